// File: doc/BRIEF.md
# Generation-Bit Completion Ring Writer

This block is the device side of a completion ring in which the host learns about new entries from a single generation bit in each entry. There is no producer index register. Each completion request carries a 16-bit tag, which is either a transmit completion tag or a receive buffer identifier. A request may also carry an end-of-packet marker, because one received packet can occupy several consecutive entries. The writer stores the entry in the next ring slot, stamped with its current generation value. It then advances its slot index and inverts the generation each time that index wraps.

The host fills every slot's generation bit with zero before any traffic. A host-side reader model is built into the block. The reader watches the slot it expects next and treats the slot as new when the slot's generation bit differs from the stale value it holds for that lap. The reader inverts that stale value whenever its own index wraps. Overrun protection uses credits. The writer starts with one credit per slot, spends one credit on each write and gets one back on each reader pop. When no credits remain it stalls instead of overwriting.

Top module: `cq_gen_ring_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0 and `cq_wr_en` is 0.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. In that same cycle `cq_wr_en` is 1, and the entry is written into slot `cq_wr_idx` at the next rising edge.
- R3: The write index starts at 0 and advances by one per accepted request. It returns to 0 after slot DEPTH-1.
- R4: Entries written during the first lap carry generation bit 1. The written generation bit inverts each time the write index wraps.
- R5: The entry is a 32-bit little-endian word. Bits [15:0] hold the tag, so byte lane 0 carries tag[7:0] and byte lane 1 carries tag[15:8]. Bit 16 is the end-of-packet flag, bit 31 is the generation bit, and all other bits are 0.
- R6: At most DEPTH entries are ever unconsumed. With DEPTH entries outstanding, `req_ready` is 0, and a request presented then causes no write.
- R7: A reader pop returns one credit, so `req_ready` is 1 in the cycle after a pop that made room.
- R8: `rd_valid` is 1 exactly when the reader's slot holds a generation bit different from its stale expectation. The reader inverts that expectation on every wrap. Entries reach `rd_tag` in write order with their tag intact.
- R9: The entries of a multi-entry packet occupy consecutive slots. Only the final entry carries the end-of-packet flag on `rd_last`.
- R10: `rd_pop` while `rd_valid` is 0 has no effect. The next entry written is still the next one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Completion request present |
| req_tag | input | 16 | Completion tag or buffer identifier |
| req_last | input | 1 | Request is the final entry of its packet |
| req_ready | output | 1 | A free slot credit is available |
| cq_wr_en | output | 1 | Entry write to the ring this cycle |
| cq_wr_idx | output | $clog2(DEPTH) | Slot being written |
| cq_wr_data | output | 32 | Entry word being written |
| rd_pop | input | 1 | Host consumes the entry at its read slot |
| rd_valid | output | 1 | Reader slot holds a new entry |
| rd_tag | output | 16 | Tag of the reader slot |
| rd_last | output | 1 | End-of-packet flag of the reader slot |

## Verification
Several properties are checked on every cycle. A stalled writer never writes, and the credit count never exceeds the ring depth. The write index steps by one per accepted write, the generation flips on a write-side wrap, a pop returns its credit, and an empty pop leaves the reader still. Other behaviour only shows over a scenario. The exact bit layout of the entry word, the in-order delivery of tags across several laps of both generations, the end-of-packet flag on multi-entry packets and the recovery from a full ring can only be confirmed by the bench's directed sequences.

// File: rtl/cq_ring_pkg.sv
`timescale 1ns/1ps
package cq_ring_pkg;
  localparam int unsigned TAG_W    = 16;
  localparam int unsigned ENTRY_W  = 32;
  localparam int unsigned GEN_POS  = 31;
  localparam int unsigned LAST_POS = 16;

  typedef struct packed {
    logic             last;
    logic [TAG_W-1:0] tag;
  } cq_payload_t;

  // Entry word: little-endian, tag in the low byte lanes.
  function automatic logic [ENTRY_W-1:0] cq_pack(input logic gen,
                                                 input logic last,
                                                 input logic [TAG_W-1:0] tag);
    logic [ENTRY_W-1:0] w;
    w = '0;
    w[TAG_W-1:0] = tag;
    w[LAST_POS]  = last;
    w[GEN_POS]   = gen;
    return w;
  endfunction
endpackage

// File: rtl/cq_writer.sv
`timescale 1ns/1ps
module cq_writer #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          rd_fire,
  output logic          req_ready,
  output logic          wr_fire,
  output logic [IW-1:0] wr_idx,
  output logic          wr_gen,
  output logic [CW-1:0] credits
);
  logic cur_gen;

  function automatic logic [IW-1:0] idx_step(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [CW-1:0] credit_next(input logic [CW-1:0] c,
                                                input logic spend,
                                                input logic refund);
    logic [CW-1:0] r;
    case ({spend, refund})
      2'b10:   r = c - 1'b1;
      2'b01:   r = c + 1'b1;
      default: r = c;
    endcase
    return r;
  endfunction

  assign req_ready = (credits != '0);
  assign wr_fire   = req_valid && req_ready;
  assign wr_gen    = ~cur_gen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      cur_gen <= 1'b0;
      credits <= CW'(DEPTH);
    end else begin
      credits <= credit_next(credits, wr_fire, rd_fire);
      if (wr_fire) begin
        wr_idx <= idx_step(wr_idx);
        if (wr_idx == IW'(DEPTH - 1)) cur_gen <= ~cur_gen;
      end
    end
  end
endmodule

// File: rtl/cq_ring_mem.sv
`timescale 1ns/1ps
module cq_ring_mem
  import cq_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic          wgen,
  input  cq_payload_t   wpay,
  input  logic [IW-1:0] raddr,
  output logic          rgen,
  output cq_payload_t   rpay
);
  logic        gen_q [DEPTH];
  cq_payload_t pay_q [DEPTH];

  // Generation bits are host-initialised to the starting value (zero).
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                         gen_q[s] <= 1'b0;
      else if (we && waddr == IW'(s))     gen_q[s] <= wgen;
    end
    always_ff @(posedge clk) begin
      if (we && waddr == IW'(s)) pay_q[s] <= wpay;
    end
  end

  assign rgen = gen_q[raddr];
  assign rpay = pay_q[raddr];
endmodule

// File: rtl/cq_reader.sv
`timescale 1ns/1ps
module cq_reader #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_pop,
  input  logic          slot_gen,
  output logic          rd_valid,
  output logic          rd_fire,
  output logic [IW-1:0] rd_idx
);
  logic stale_gen;

  function automatic logic [IW-1:0] idx_step(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign rd_valid = (slot_gen != stale_gen);
  assign rd_fire  = rd_pop && rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx    <= '0;
      stale_gen <= 1'b0;
    end else if (rd_fire) begin
      rd_idx <= idx_step(rd_idx);
      if (rd_idx == IW'(DEPTH - 1)) stale_gen <= ~stale_gen;
    end
  end
endmodule

// File: rtl/cq_gen_ring_top.sv
`timescale 1ns/1ps
module cq_gen_ring_top
  import cq_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic               req_last,
  output logic               req_ready,
  output logic               cq_wr_en,
  output logic [IW-1:0]      cq_wr_idx,
  output logic [ENTRY_W-1:0] cq_wr_data,
  input  logic               rd_pop,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               rd_last
);
  // Named internal events, observed by the bound checker.
  logic          wr_fire;
  logic          rd_fire;
  logic          wr_gen;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic [CW-1:0] credits;
  logic          slot_gen;
  cq_payload_t   wpay;
  cq_payload_t   rpay;

  cq_writer #(.DEPTH(DEPTH)) writer_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rd_fire(rd_fire),
    .req_ready(req_ready), .wr_fire(wr_fire), .wr_idx(wr_idx),
    .wr_gen(wr_gen), .credits(credits)
  );

  assign wpay.last = req_last;
  assign wpay.tag  = req_tag;

  cq_ring_mem #(.DEPTH(DEPTH)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(wr_idx), .wgen(wr_gen),
    .wpay(wpay), .raddr(rd_idx), .rgen(slot_gen), .rpay(rpay)
  );

  cq_reader #(.DEPTH(DEPTH)) reader_i (
    .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .slot_gen(slot_gen),
    .rd_valid(rd_valid), .rd_fire(rd_fire), .rd_idx(rd_idx)
  );

  assign cq_wr_en   = wr_fire;
  assign cq_wr_idx  = wr_idx;
  assign cq_wr_data = cq_pack(wr_gen, req_last, req_tag);
  assign rd_tag     = rpay.tag;
  assign rd_last    = rpay.last;
endmodule

// File: rtl/cq_gen_ring_chk.sv
`timescale 1ns/1ps
module cq_gen_ring_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          cq_wr_en,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          rd_pop,
  input logic          rd_valid,
  input logic          wr_gen,
  input logic [IW-1:0] wr_idx,
  input logic [IW-1:0] rd_idx,
  input logic [CW-1:0] credits
);
  a_r6_no_write_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !cq_wr_en);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= CW'(DEPTH));

  a_r3_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx != IW'(DEPTH - 1)) |=> wr_idx == $past(wr_idx) + 1'b1);

  a_r3_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IW'(DEPTH - 1)) |=> wr_idx == '0);

  a_r4_gen_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == IW'(DEPTH - 1)) |=> wr_gen != $past(wr_gen));

  a_r7_credit_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !wr_fire) |=> credits == $past(credits) + 1'b1);

  a_r10_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !rd_valid) |=> $stable(rd_idx));
endmodule

bind cq_gen_ring_top cq_gen_ring_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cq_wr_en(cq_wr_en),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .rd_pop(rd_pop), .rd_valid(rd_valid),
  .wr_gen(wr_gen), .wr_idx(wr_idx), .rd_idx(rd_idx), .credits(credits)
);

// File: tb/cq_gen_ring_top_tb_top.sv
`timescale 1ns/1ps
module cq_gen_ring_top_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_tag = '0;
  logic        req_last = 1'b0;
  logic        req_ready;
  logic        cq_wr_en;
  logic [2:0]  cq_wr_idx;
  logic [31:0] cq_wr_data;
  logic        rd_pop = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_tag;
  logic        rd_last;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int          exp_widx = 0;
  logic        exp_gen = 1'b1;
  logic [16:0] fifo_q[$];

  always #2 clk = ~clk;

  cq_gen_ring_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .req_last(req_last), .req_ready(req_ready), .cq_wr_en(cq_wr_en),
    .cq_wr_idx(cq_wr_idx), .cq_wr_data(cq_wr_data), .rd_pop(rd_pop),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_last(rd_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] tag, input logic last);
    logic [31:0] exp_w;
    @(negedge clk);
    req_valid = 1'b1; req_tag = tag; req_last = last;
    #1;
    exp_w = {exp_gen, 14'h0, last, tag};
    chk(req_ready && cq_wr_en, "R2 accept", {30'h0, req_ready, cq_wr_en}, 32'h3);
    chk(int'(cq_wr_idx) == exp_widx, "R3 write index", 32'(cq_wr_idx), 32'(exp_widx));
    chk(cq_wr_data[31] == exp_gen, "R4 generation bit", 32'(cq_wr_data[31]), 32'(exp_gen));
    chk(cq_wr_data == exp_w, "R5 entry word", cq_wr_data, exp_w);
    @(posedge clk); #1;
    req_valid = 1'b0;
    fifo_q.push_back({last, tag});
    if (exp_widx == DEPTH - 1) begin exp_widx = 0; exp_gen = ~exp_gen; end
    else exp_widx++;
  endtask

  task automatic pop_check(input string req);
    logic [16:0] e;
    @(negedge clk); #1;
    e = fifo_q.pop_front();
    chk(rd_valid == 1'b1, {req, " valid"}, 32'(rd_valid), 32'h1);
    chk(rd_tag == e[15:0], {req, " tag order"}, 32'(rd_tag), 32'(e[15:0]));
    chk(rd_last == e[16], {req, " last flag"}, 32'(rd_last), 32'(e[16]));
    rd_pop = 1'b1;
    @(posedge clk); #1;
    rd_pop = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
    chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 32'h0);
    chk(cq_wr_en == 1'b0, "R1 wr_en", 32'(cq_wr_en), 32'h0);
  endtask

  task automatic t_single;
    push(16'hA55A, 1'b1);
    pop_check("R8 single");
    @(negedge clk); #1;
    chk(rd_valid == 1'b0, "R8 empty after pop", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_byte_lanes;
    push(16'h12F0, 1'b0);
    pop_check("R5 readback");
  endtask

  task automatic t_fill_stall;
    for (int i = 0; i < DEPTH; i++) push(16'h3000 + 16'(i), 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_tag = 16'hDEAD; req_last = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R6 full stall", 32'(req_ready), 32'h0);
    chk(cq_wr_en == 1'b0, "R6 no write when full", 32'(cq_wr_en), 32'h0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    pop_check("R8 drain");
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R7 credit back", 32'(req_ready), 32'h1);
    for (int i = 1; i < DEPTH; i++) pop_check("R6 nothing overwritten");
    @(negedge clk); #1;
    chk(rd_valid == 1'b0, "R6 no extra entry", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 3 * DEPTH + 3; i++) begin
      push(16'h5000 + 16'(i * 7), 1'(i % 2));
      pop_check("R8 wrap lap");
    end
  endtask

  task automatic t_multi;
    push(16'h0101, 1'b0);
    push(16'h0102, 1'b0);
    push(16'h0103, 1'b1);
    pop_check("R9 packet part 1");
    pop_check("R9 packet part 2");
    pop_check("R9 packet end");
  endtask

  task automatic t_empty_pop;
    @(negedge clk); #1;
    chk(rd_valid == 1'b0, "R10 empty", 32'(rd_valid), 32'h0);
    rd_pop = 1'b1;
    repeat (3) @(posedge clk);
    #1; rd_pop = 1'b0;
    chk(rd_valid == 1'b0, "R10 still empty", 32'(rd_valid), 32'h0);
    push(16'hBEEF, 1'b1);
    pop_check("R10 next read after empty pop");
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single();
    t_byte_lanes();
    t_fill_stall();
    t_wrap();
    t_multi();
    t_empty_pop();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule